// File: doc/BRIEF.md
# Transponder Request/Reply Framer

This block is the digital framing stage of a challenge-response transponder. A demodulator delivers the reader's request one bit per handshake. The framer collects an 8-bit command code and a 40-bit challenge, both most significant bit first. When the command code is the one challenge command the block recognises, it hands the challenge to an external cipher and waits for the cipher to finish. It then sends back a 64-bit reply, one bit per handshake, to a modulator: the device serial number, then the 24-bit truncated cipher result (the signature), then a 16-bit CRC whose start value is a secret shared with the reader.

Both data streams use valid/ready handshakes. A bit moves only in a cycle where valid and ready are both high. The framer lowers `rx_ready` from the cycle after the last request bit until the reply has fully left, so the upstream side must hold a bit until it is taken. On the reply side, the framer keeps `tx_valid` high and `tx_bit` steady while `tx_ready` is low, so the downstream side may stall it for any number of cycles. The cipher ports and the static serial/seed inputs are plain signals. A request that pauses for too long between bits is dropped, so that a broken frame cannot misalign the next one.

Top module: `xpdr_framer`

## Requirements
- R1: After reset, `rx_ready` is 1, `tx_valid` is 0 and `ciph_start` is 0.
- R2: A request is 48 bits, taken only when `rx_valid` and `rx_ready` are both high, most significant bit first. The first 8 bits are the command code and the remaining 40 bits are the challenge.
- R3: If the command code equals `CHAL_OPCODE` (default 8'hB3), `ciph_start` is high for exactly one cycle, starting the cycle after the last request bit is taken. From that cycle until the reply ends, `rx_ready` is low and `ciph_challenge` holds the received challenge unchanged.
- R4: A complete request with any other command code produces no `ciph_start` and no reply. `rx_ready` stays high, and the next bit taken is the first bit of a new request.
- R5: `ciph_done` has an effect only in the state that waits for the cipher; a pulse at any other time is ignored. When `ciph_done` is accepted, `tx_valid` rises on the next cycle.
- R6: The reply is 64 bits, most significant bit first, in this order: `serial_num[23:0]`, then `ciph_result[23:0]` as sampled in the cycle `ciph_done` is accepted, then the 16-bit CRC.
- R7: The CRC uses the polynomial x^16+x^12+x^5+1 (0x1021), starts from `crc_seed`, and takes in the 48 serial and signature bits most significant bit first. There is no final inversion. The CRC is sent most significant bit first.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_bit` does not change. After the 64th handshake, `tx_valid` is low and `rx_ready` is high on the next cycle.
- R9: Once at least one request bit has been taken, `STALL_LIMIT` (default 12) consecutive cycles without a taken bit discard the partial request. A pause of `STALL_LIMIT-1` cycles does not discard it.
- R10: `serial_num` and `crc_seed` are captured when `ciph_done` is accepted. Changing them while the reply is being sent does not change any reply bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Request bit valid |
| rx_ready | output | 1 | Framer can take a request bit |
| rx_bit | input | 1 | Request bit |
| tx_valid | output | 1 | Reply bit valid |
| tx_ready | input | 1 | Downstream takes the reply bit |
| tx_bit | output | 1 | Reply bit |
| ciph_start | output | 1 | One-cycle pulse that starts encryption |
| ciph_challenge | output | 40 | Challenge passed to the cipher |
| ciph_done | input | 1 | Cipher has finished |
| ciph_result | input | 24 | Low 24 bits of the cipher's challenge register |
| serial_num | input | 24 | Factory serial number |
| crc_seed | input | 16 | Secret CRC start value |

## Verification
The reference model predicts `rx_ready`, `ciph_start`, `tx_valid`, `tx_bit` and `ciph_challenge` every cycle. A wrong bit counter or a wrong stall timer shows up as a misaligned command code: the expected `ciph_start` does not appear in the cycle after the 48th bit, or an unexpected one does. A wrong CRC register or a wrong shift register is not visible until the reply is sent. It then shows at the first wrong bit and no later than the 64th handshake. Stalls on the reply side and changes to the static inputs mid-reply check that captured state is held rather than read again.

// File: rtl/xf_pkg.sv
package xf_pkg;
  typedef enum logic [1:0] {
    ST_RX    = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2,
    ST_TX    = 2'd3
  } xf_state_e;
endpackage

// File: rtl/xf_crc_step.sv
module xf_crc_step #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic             in_bit,
  output logic [CRC_W-1:0] crc_out
);
  logic fb;
  always_comb begin
    fb      = crc_in[CRC_W-1] ^ in_bit;
    crc_out = {crc_in[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
  end
endmodule

// File: rtl/xf_rx_deser.sv
module xf_rx_deser #(
  parameter int FRAME_W     = 48,
  parameter int STALL_LIMIT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int GAP_W = $clog2(STALL_LIMIT + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [GAP_W-1:0]   gap_q;
  logic               take;

  assign take       = en && in_valid;
  assign frame_done = take && (cnt_q == CNT_W'(FRAME_W - 1));
  assign frame_word = {shreg_q[FRAME_W-2:0], in_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else if (take) begin
      shreg_q <= frame_word;
      gap_q   <= '0;
      cnt_q   <= frame_done ? '0 : cnt_q + 1'b1;
    end else if (cnt_q != '0) begin
      if (gap_q == GAP_W'(STALL_LIMIT - 1)) begin
        cnt_q <= '0;
        gap_q <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_gap_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GAP_W'(STALL_LIMIT))
    else $error("stall timer passed its limit");

  assert_idle_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (gap_q == '0))
    else $error("stall timer running with no partial frame");
endmodule

// File: rtl/xf_tx_ser.sv
module xf_tx_ser #(
  parameter int          DATA_W = 48,
  parameter int          CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [CRC_W-1:0]  load_seed,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_bit,
  output logic              last
);
  localparam int REPLY_W = DATA_W + CRC_W;
  localparam int CNT_W   = $clog2(REPLY_W);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nxt;
  logic              in_data;
  logic              hs;

  xf_crc_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_in (crc_q),
    .in_bit (data_q[DATA_W-1]),
    .crc_out(crc_nxt)
  );

  assign in_data   = cnt_q < CNT_W'(DATA_W);
  assign hs        = active_q && out_ready;
  assign last      = hs && (cnt_q == CNT_W'(REPLY_W - 1));
  assign out_valid = active_q;
  assign out_bit   = in_data ? data_q[DATA_W-1] : crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      data_q   <= '0;
      crc_q    <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      data_q   <= load_data;
      crc_q    <= load_seed;
    end else if (hs) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (last) active_q <= 1'b0;
      if (in_data) begin
        data_q <= {data_q[DATA_W-2:0], 1'b0};
        crc_q  <= crc_nxt;
      end else begin
        crc_q <= {crc_q[CRC_W-2:0], 1'b0};
      end
    end
  end

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)))
    else $error("reply bit dropped or changed under back-pressure");

  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active_q)
    else $error("reply loaded while previous reply active");
endmodule

// File: rtl/xpdr_framer.sv
module xpdr_framer #(
  parameter int          OPC_W       = 8,
  parameter int          CHAL_W      = 40,
  parameter int          SER_W       = 24,
  parameter int          SIG_W       = 24,
  parameter int          CRC_W       = 16,
  parameter logic [15:0] CRC_POLY    = 16'h1021,
  parameter logic [7:0]  CHAL_OPCODE = 8'hB3,
  parameter int          STALL_LIMIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_bit,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_bit,
  output logic              ciph_start,
  output logic [CHAL_W-1:0] ciph_challenge,
  input  logic              ciph_done,
  input  logic [SIG_W-1:0]  ciph_result,
  input  logic [SER_W-1:0]  serial_num,
  input  logic [CRC_W-1:0]  crc_seed
);
  import xf_pkg::*;

  localparam int FRAME_W = OPC_W + CHAL_W;
  localparam int DATA_W  = SER_W + SIG_W;

  xf_state_e          state_q;
  logic [CHAL_W-1:0]  chal_q;
  logic               frame_done;
  logic [FRAME_W-1:0] frame_word;
  logic               opc_hit;
  logic               tx_load;
  logic               tx_last;

  xf_rx_deser #(.FRAME_W(FRAME_W), .STALL_LIMIT(STALL_LIMIT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_ready),
    .in_valid  (rx_valid),
    .in_bit    (rx_bit),
    .frame_done(frame_done),
    .frame_word(frame_word)
  );

  assign opc_hit = frame_word[FRAME_W-1 -: OPC_W] == CHAL_OPCODE[OPC_W-1:0];
  assign tx_load = (state_q == ST_WAIT) && ciph_done;

  xf_tx_ser #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_data({serial_num, ciph_result}),
    .load_seed(crc_seed),
    .out_ready(tx_ready),
    .out_valid(tx_valid),
    .out_bit  (tx_bit),
    .last     (tx_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RX;
      chal_q  <= '0;
    end else begin
      unique case (state_q)
        ST_RX: if (frame_done && opc_hit) begin
          chal_q  <= frame_word[CHAL_W-1:0];
          state_q <= ST_START;
        end
        ST_START: state_q <= ST_WAIT;
        ST_WAIT:  if (ciph_done) state_q <= ST_TX;
        ST_TX:    if (tx_last) state_q <= ST_RX;
        default:  state_q <= ST_RX;
      endcase
    end
  end

  assign rx_ready       = state_q == ST_RX;
  assign ciph_start     = state_q == ST_START;
  assign ciph_challenge = chal_q;

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ciph_start |=> !ciph_start)
    else $error("cipher start longer than one cycle");

  assert_chal_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && $past(!rx_ready)) |-> $stable(ciph_challenge))
    else $error("challenge changed during a transaction");

  assert_no_rx_in_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready)
    else $error("request accepted while replying");

  assert_reply_follows_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_valid)
    else $error("reply did not start after cipher done");
endmodule

// File: tb/xpdr_framer_tb.sv
module xpdr_framer_tb;
  localparam logic [7:0] OPC   = 8'hB3;
  localparam int         STALL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_bit = 1'b0;
  logic        rx_ready, tx_valid, tx_bit, ciph_start;
  logic        tx_ready = 1'b1;
  logic [39:0] ciph_challenge;
  logic        emu_done = 1'b0, stray_done = 1'b0;
  logic        ciph_done;
  logic [23:0] ciph_result = '0;
  logic [23:0] serial_num = 24'hA1B2C3;
  logic [15:0] crc_seed = 16'h5EED;

  assign ciph_done = emu_done | stray_done;

  always #5 clk = ~clk;

  xpdr_framer u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .ciph_start(ciph_start), .ciph_challenge(ciph_challenge),
    .ciph_done(ciph_done), .ciph_result(ciph_result),
    .serial_num(serial_num), .crc_seed(crc_seed)
  );

  int checks = 0, errors = 0, cyc = 0, replies = 0, starts = 0;
  int tx_mode = 0, emu_cnt = 0, emu_lat = 4;
  logic [39:0] exp_chal = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [47:0] d, input logic [15:0] s);
    logic [15:0] c = s;
    for (int i = 47; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // behavioural reference model, advanced on every rising edge
  int          mst = 0, mcnt = 0, mgap = 0;
  logic [47:0] mshift = '0;
  logic [39:0] mchal = '0;
  logic [63:0] exp_word = '0, got = '0;
  bit          mq[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      mst = 0; mcnt = 0; mgap = 0; mq.delete();
    end else begin
      case (mst)
        0: if (rx_valid) begin
             mshift = {mshift[46:0], rx_bit};
             mgap = 0;
             mcnt++;
             if (mcnt == 48) begin
               mcnt = 0;
               if (mshift[47:40] == OPC) begin mchal = mshift[39:0]; mst = 1; end
             end
           end else if (mcnt != 0) begin
             mgap++;
             if (mgap == STALL) begin mcnt = 0; mgap = 0; end
           end
        1: mst = 2;
        2: if (ciph_done) begin
             exp_word = {serial_num, ciph_result, crc_of({serial_num, ciph_result}, crc_seed)};
             for (int i = 63; i >= 0; i--) mq.push_back(exp_word[i]);
             mst = 3;
           end
        default: if (tx_ready) begin
             got = {got[62:0], tx_bit};
             void'(mq.pop_front());
             if (mq.size() == 0) begin
               mst = 0;
               replies++;
               chk(got == exp_word, "R6 R7 reply word", got, exp_word);
             end
           end
      endcase
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_ready == (mst == 0), "R2 R4 R9 rx_ready", 64'(rx_ready), 64'(mst == 0));
      chk(ciph_start == (mst == 1), "R3 ciph_start", 64'(ciph_start), 64'(mst == 1));
      chk(tx_valid == (mst == 3), "R5 R8 tx_valid", 64'(tx_valid), 64'(mst == 3));
      if (mst == 3)
        chk(tx_bit == mq[0], "R6 R10 tx_bit", 64'(tx_bit), 64'(mq[0]));
      if (mst != 0)
        chk(ciph_challenge == mchal, "R3 challenge hold", 64'(ciph_challenge), 64'(mchal));
    end
  end

  // cipher emulator and reply back-pressure
  always @(negedge clk) begin
    emu_done = 1'b0;
    if (emu_cnt > 0) begin
      emu_cnt--;
      if (emu_cnt == 0) begin
        emu_done = 1'b1;
        ciph_result = ciph_challenge[23:0] ^ 24'h3C96A5;
      end
    end
    if (ciph_start) begin
      starts++;
      chk(ciph_challenge == exp_chal, "R3 challenge value", 64'(ciph_challenge), 64'(exp_chal));
      emu_cnt = emu_lat;
    end
    tx_ready = (tx_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  task automatic send_bits(input logic [47:0] w, input int hi, input int lo, input int gap);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_bit   = w[i];
      if (gap > 0 && i != lo) begin
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_reply();
    int n = 0;
    while (!tx_valid && n < 200) begin @(negedge clk); n++; end
    while (tx_valid && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_ready === 1'b1 && tx_valid === 1'b0 && ciph_start === 1'b0, "R1 reset state",
        {61'd0, rx_ready, tx_valid, ciph_start}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready === 1'b1 && tx_valid === 1'b0, "R1 after release",
        {62'd0, rx_ready, tx_valid}, 64'h2);

    // R5: stray done while idle
    stray_done = 1'b1; @(negedge clk); stray_done = 1'b0;
    repeat (3) @(negedge clk);

    // R2 R3 R6 R7: basic frame with single-cycle gaps
    exp_chal = 40'h123456789A;
    send_bits({OPC, exp_chal}, 47, 0, 1);
    wait_reply();
    chk(replies == 1, "R6 first reply", 64'(replies), 64'd1);

    // R4: wrong command code, then an immediate good frame
    send_bits({8'h3C, 40'hDEADBEEF01}, 47, 0, 0);
    repeat (8) @(negedge clk);
    chk(starts == 1, "R4 no start for bad opcode", 64'(starts), 64'd1);
    chk(replies == 1, "R4 no reply for bad opcode", 64'(replies), 64'd1);
    exp_chal = 40'h00FFFF0000;
    emu_lat = 1;
    send_bits({OPC, exp_chal}, 47, 0, 0);
    wait_reply();
    chk(replies == 2, "R4 clean restart", 64'(replies), 64'd2);

    // R8 R10: back-pressure, stray done and input changes mid-reply
    tx_mode = 1;
    emu_lat = 7;
    serial_num = 24'h0F1E2D;
    crc_seed = 16'hFFFF;
    exp_chal = 40'hFF0000FFFF;
    send_bits({OPC, exp_chal}, 47, 0, 0);
    while (!tx_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    serial_num = 24'h777777;
    crc_seed = 16'h0000;
    stray_done = 1'b1; @(negedge clk); stray_done = 1'b0;
    wait_reply();
    chk(replies == 3, "R8 stalled reply done", 64'(replies), 64'd3);
    tx_mode = 0;

    // R9: pause of STALL-1 cycles is tolerated
    exp_chal = 40'hA5A5C3C3E1;
    emu_lat = 3;
    send_bits({OPC, exp_chal}, 47, 28, 0);
    repeat (STALL - 2) @(negedge clk);
    send_bits({OPC, exp_chal}, 27, 0, 0);
    wait_reply();
    chk(replies == 4, "R9 short pause kept", 64'(replies), 64'd4);

    // R9: pause of STALL cycles discards the partial frame
    send_bits({OPC, 40'h1111111111}, 47, 38, 0);
    repeat (STALL - 1) @(negedge clk);
    exp_chal = 40'h2468ACE013;
    send_bits({OPC, exp_chal}, 47, 0, 0);
    wait_reply();
    chk(replies == 5, "R9 long pause discarded", 64'(replies), 64'd5);
    chk(starts == 5, "R3 start count", 64'(starts), 64'd5);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule